// File: doc/BRIEF.md
# PLL Lock Timer and Clock-Source Selector

This block decides which of two clock generators feeds a downstream consumer: a digital PLL, which is the default after reset, or an analog PLL. Software reaches it through two 16-bit registers on a small synchronous bus. The selection register holds the requested source and two read-only flags that show which source is really in use. The control register sets the analog PLL's multiplier and divider configuration, its VCO enable and its operating mode, and it also carries an 8-bit lock countdown.

From the configuration fields the block works out the output ratio M/D. This decoding is not regular: K = MULT + 1, and the result depends on the mode, on the divide bit, on whether K is odd or even, and on whether K is at its maximum.

When multiply mode is active, the lock countdown steps down once for every 16 reference-clock cycles. When it reaches zero, the lock flag is set. The consumer is moved to the analog PLL only once that flag is set and the analog source has been requested.

Top module: `clk_src_lock_ctrl`

## Requirements
- R1: After reset the selection register (address 0) reads 0x0004, the control register (address 1) reads 0x0000, and src_sel_o, lock_o and vco_en_o are all 0.
- R2: Bit 0 of the selection register is the source request (0 = digital, 1 = analog) and is read/write. Bits 15..3 always read 0. Writes to the status bits 2..1 have no effect.
- R3: The control register has this layout: MULT in bits 15..12, DIV in bit 11, COUNT in bits 10..3, ON in bit 2, MODE in bit 1, STAT in bit 0. STAT is read-only, and writing bit 0 has no effect.
- R4: K = MULT + 1, which ranges from 1 to 16. With MODE = 0, ratio_m_o = 1, and ratio_d_o = 2 for K below 16 or 4 for K = 16. Both outputs are plain binary values.
- R5: With MODE = 1 and DIV = 0, ratio_m_o = K and ratio_d_o = 1 for K below 16. For K = 16, ratio_m_o = 1 and ratio_d_o = 1.
- R6: With MODE = 1 and DIV = 1, an odd K gives ratio_m_o = K and ratio_d_o = 2. An even K gives ratio_m_o = K - 1 and ratio_d_o = 4.
- R7: vco_en_o is 1 exactly when ON or MODE is 1.
- R8: A control write at clock edge E0 that sets MODE = 1 with COUNT = N restarts the timer. COUNT then decreases by one every 16 edges, first at E16, and lock_o (STAT) goes to 1 at edge E(16N+1).
- R9: A control write that changes MULT, DIV or MODE clears STAT and restarts the countdown from the newly written COUNT. A control write that changes none of these leaves STAT unchanged. With MODE = 0, STAT stays 0.
- R10: src_sel_o goes to 1 one edge after the source request and STAT are both 1, and it returns to 0 one edge after either of them drops. Selection-register bit 1 reads src_sel_o and bit 2 reads its inverse, so the two are never both 1.
- R11: rdata_o is registered: it shows the register selected by addr_i at the previous edge. Unmapped addresses read 0, and writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| src_sel_o | output | 1 | 1 routes the analog PLL clock to the consumer |
| vco_en_o | output | 1 | Analog PLL VCO enable |
| lock_o | output | 1 | Lock status (STAT) |
| ratio_m_o | output | 5 | Decoded multiplier M |
| ratio_d_o | output | 3 | Decoded divider D |

## Verification
If the countdown state is wrong, the edge on which lock_o rises moves by a multiple of 16 cycles. The same error shows in COUNT readbacks taken partway through a countdown, within one prescaler period. A wrong configuration latch appears at ratio_m_o, ratio_d_o and vco_en_o on the first falling clock edge after the write. A lock flag that is not cleared when it should be shows up one edge later, either at src_sel_o or in the selection-register status bits.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned MULT_W  = 4;
  localparam int unsigned COUNT_W = 8;
  localparam int unsigned K_W     = MULT_W + 1;
  localparam int unsigned D_W     = 3;

  // control register bit positions
  localparam int unsigned MULT_LSB  = 12;
  localparam int unsigned DIV_BIT   = 11;
  localparam int unsigned COUNT_LSB = 3;
  localparam int unsigned ON_BIT    = 2;
  localparam int unsigned MODE_BIT  = 1;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic              div;
    logic              on;
    logic              mode;
  } pll_cfg_t;
endpackage

// File: rtl/clk_src_regs.sv
module clk_src_regs
  import clk_src_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SEL_ADDR  = 0,
  parameter int unsigned CTRL_ADDR = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [COUNT_W-1:0] count_i,
  input  logic               stat_i,
  input  logic               act_analog_i,
  output logic [DATA_W-1:0]  rdata_o,
  output pll_cfg_t           cfg_o,
  output logic               sel_o,
  output logic               ctrl_wr_o,
  output logic               cfg_chg_o
);
  pll_cfg_t            cfg_q, cfg_new;
  logic                sel_q;
  logic [DATA_W-1:0]   rdata_q, sel_word, ctrl_word;
  logic                sel_wr;

  assign sel_wr    = we_i && (addr_i == ADDR_W'(SEL_ADDR));
  assign ctrl_wr_o = we_i && (addr_i == ADDR_W'(CTRL_ADDR));

  always_comb begin
    cfg_new.mult = wdata_i[MULT_LSB +: MULT_W];
    cfg_new.div  = wdata_i[DIV_BIT];
    cfg_new.on   = wdata_i[ON_BIT];
    cfg_new.mode = wdata_i[MODE_BIT];
  end

  assign cfg_chg_o = ctrl_wr_o &&
                     ((cfg_new.mult != cfg_q.mult) || (cfg_new.div != cfg_q.div) ||
                      (cfg_new.mode != cfg_q.mode));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      sel_q <= 1'b0;
    end else begin
      if (ctrl_wr_o) cfg_q <= cfg_new;
      if (sel_wr)    sel_q <= wdata_i[0];
    end
  end

  always_comb begin
    sel_word    = '0;
    sel_word[0] = sel_q;
    sel_word[1] = act_analog_i;
    sel_word[2] = ~act_analog_i;
    ctrl_word   = '0;
    ctrl_word[MULT_LSB +: MULT_W]   = cfg_q.mult;
    ctrl_word[DIV_BIT]              = cfg_q.div;
    ctrl_word[COUNT_LSB +: COUNT_W] = count_i;
    ctrl_word[ON_BIT]               = cfg_q.on;
    ctrl_word[MODE_BIT]             = cfg_q.mode;
    ctrl_word[0]                    = stat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (addr_i == ADDR_W'(SEL_ADDR))  rdata_q <= sel_word;
    else if (addr_i == ADDR_W'(CTRL_ADDR)) rdata_q <= ctrl_word;
    else rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
  assign cfg_o   = cfg_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/clk_ratio_dec.sv
module clk_ratio_dec
  import clk_src_pkg::*;
(
  input  pll_cfg_t        cfg_i,
  output logic [K_W-1:0]  m_o,
  output logic [D_W-1:0]  d_o
);
  localparam logic [K_W-1:0] K_MAX = K_W'(1 << MULT_W);

  logic [K_W-1:0] k;
  logic           k_top;

  assign k     = K_W'(cfg_i.mult) + K_W'(1);
  assign k_top = (k == K_MAX);

  always_comb begin
    if (!cfg_i.mode) begin
      m_o = K_W'(1);
      d_o = k_top ? D_W'(4) : D_W'(2);
    end else if (!cfg_i.div) begin
      m_o = k_top ? K_W'(1) : k;
      d_o = D_W'(1);
    end else if (k[0]) begin
      m_o = k;
      d_o = D_W'(2);
    end else begin
      m_o = k - K_W'(1);
      d_o = D_W'(4);
    end
  end
endmodule

// File: rtl/clk_lock_timer.sv
module clk_lock_timer
  import clk_src_pkg::*;
#(
  parameter int unsigned PRESCALE = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [COUNT_W-1:0] wcount_i,
  input  logic               clr_i,
  input  logic               mode_i,
  output logic [COUNT_W-1:0] count_o,
  output logic               stat_o
);
  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [COUNT_W-1:0] count_q;
  logic               stat_q;
  logic               tick;
  logic               run;

  assign run = mode_i && !stat_q && (count_q != '0) && !wr_i;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   pre_q <= '0;
        else if (wr_i || !run || tick) pre_q <= '0;
        else                           pre_q <= pre_q + PRE_W'(1);
      end
      assign tick = run && (pre_q == PRE_W'(PRESCALE - 1));
    end else begin : g_nopre
      assign tick = run;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      stat_q  <= 1'b0;
    end else if (wr_i) begin
      count_q <= wcount_i;
      if (clr_i) stat_q <= 1'b0;
    end else if (!mode_i) begin
      stat_q <= 1'b0;
    end else if (!stat_q) begin
      if (count_q == '0) stat_q  <= 1'b1;
      else if (tick)     count_q <= count_q - COUNT_W'(1);
    end
  end

  assign count_o = count_q;
  assign stat_o  = stat_q;
endmodule

// File: rtl/clk_src_lock_ctrl.sv
module clk_src_lock_ctrl
  import clk_src_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SEL_ADDR  = 0,
  parameter int unsigned CTRL_ADDR = 1,
  parameter int unsigned PRESCALE  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              src_sel_o,
  output logic              vco_en_o,
  output logic              lock_o,
  output logic [4:0]        ratio_m_o,
  output logic [2:0]        ratio_d_o
);
  pll_cfg_t           cfg;
  logic               sel_req, ctrl_wr, cfg_chg, stat, act_analog_q;
  logic [COUNT_W-1:0] lock_count;

  clk_src_regs #(
    .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) i_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .count_i(lock_count), .stat_i(stat), .act_analog_i(act_analog_q),
    .rdata_o, .cfg_o(cfg), .sel_o(sel_req), .ctrl_wr_o(ctrl_wr), .cfg_chg_o(cfg_chg)
  );

  clk_lock_timer #(.PRESCALE(PRESCALE)) i_timer (
    .clk_i, .rst_ni, .wr_i(ctrl_wr),
    .wcount_i(wdata_i[COUNT_LSB +: COUNT_W]), .clr_i(cfg_chg),
    .mode_i(cfg.mode), .count_o(lock_count), .stat_o(stat)
  );

  clk_ratio_dec i_dec (.cfg_i(cfg), .m_o(ratio_m_o), .d_o(ratio_d_o));

  // source moves to analog only once locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_analog_q <= 1'b0;
    else         act_analog_q <= sel_req && stat;
  end

  assign src_sel_o = act_analog_q;
  assign vco_en_o  = cfg.on || cfg.mode;
  assign lock_o    = stat;
endmodule

// File: rtl/clk_src_lock_chk.sv
module clk_src_lock_chk #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [15:0]       wdata_i,
  input logic              src_sel_o,
  input logic              vco_en_o,
  input logic              lock_o,
  input logic [4:0]        ratio_m_o,
  input logic [2:0]        ratio_d_o,
  input logic [7:0]        count_i
);
  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == ADDR_W'(CTRL_ADDR));

  assert_lock_after_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(count_i) == 8'd0);

  assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> (count_i == $past(count_i) || count_i == $past(count_i) - 8'd1));

  assert_mode_off_unlock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wdata_i[1]) |=> !lock_o);

  assert_src_needs_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_sel_o |-> $past(lock_o));

  assert_lock_vco_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> vco_en_o);

  assert_d_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ratio_d_o) == 1 && ratio_d_o != 3'd0);

  assert_m_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_m_o != 5'd0 && ratio_m_o <= 5'd16);
endmodule

bind clk_src_lock_ctrl clk_src_lock_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
  .src_sel_o(src_sel_o), .vco_en_o(vco_en_o), .lock_o(lock_o),
  .ratio_m_o(ratio_m_o), .ratio_d_o(ratio_d_o), .count_i(lock_count)
);

// File: tb/test_clk_src_lock_ctrl.sv
module test_clk_src_lock_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        src_sel, vco_en, lock;
  logic [4:0]  ratio_m;
  logic [2:0]  ratio_d;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  clk_src_lock_ctrl i_clk_src_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .src_sel_o(src_sel), .vco_en_o(vco_en), .lock_o(lock),
    .ratio_m_o(ratio_m), .ratio_d_o(ratio_d)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_m(input logic [3:0] mult, input logic dv, input logic md);
    int k = int'(mult) + 1;
    if (!md) return 5'd1;
    if (!dv) return (k == 16) ? 5'd1 : 5'(k);
    return (k % 2 == 1) ? 5'(k) : 5'(k - 1);
  endfunction

  function automatic logic [2:0] exp_d(input logic [3:0] mult, input logic dv, input logic md);
    int k = int'(mult) + 1;
    if (!md) return (k == 16) ? 3'd4 : 3'd2;
    if (!dv) return 3'd1;
    return (k % 2 == 1) ? 3'd2 : 3'd4;
  endfunction

  function automatic logic [15:0] ctrl_word(input logic [3:0] mult, input logic dv,
      input logic [7:0] cnt, input logic on, input logic md, input logic st);
    return {mult, dv, cnt, on, md, st};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic edges_to_lock(output int cyc);
    cyc = 0;
    while (!lock && cyc < 5000) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [3:0]  mult, pm;
    logic        dv, on, md, pd, pmd, lk;
    int          cyc;
    void'($urandom(32'd4242));
    pm = '0; pd = 1'b0; pmd = 1'b0; lk = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 src_sel", 32'(src_sel), 0);
    chk("R1 lock", 32'(lock), 0);
    chk("R1 vco", 32'(vco_en), 0);
    rd(4'd0, r); chk("R1 sel reg", 32'(r), 32'h0004);
    rd(4'd1, r); chk("R1 ctrl reg", 32'(r), 32'h0000);

    // R2 writes to status bits and reserved bits ignored
    wr(4'd0, 16'hFFF6);
    rd(4'd0, r); chk("R2 sel reg reserved", 32'(r), 32'h0004);
    // R11 unmapped address
    wr(4'd5, 16'hFFFF);
    rd(4'd5, r); chk("R11 unmapped read", 32'(r), 0);
    rd(4'd1, r); chk("R11 unmapped write no effect", 32'(r), 0);
    rd(4'd0, r); chk("R11 sel after unmapped write", 32'(r), 32'h0004);

    // R4/R5/R6/R7/R3 directed corners plus random configs
    for (int i = 0; i < 48; i++) begin
      if (i < 6) begin
        mult = (i % 2 == 0) ? 4'hF : 4'hE;
        dv = (i / 2 == 2); md = (i / 2 != 0); on = 1'b0;
      end else begin
        mult = 4'($urandom_range(0, 15)); dv = 1'($urandom);
        on = 1'($urandom); md = 1'($urandom);
      end
      wr(4'd1, ctrl_word(mult, dv, 8'd0, on, md, 1'($urandom)));
      chk(!md ? "R4 ratio m" : (!dv ? "R5 ratio m" : "R6 ratio m"),
          32'(ratio_m), 32'(exp_m(mult, dv, md)));
      chk(!md ? "R4 ratio d" : (!dv ? "R5 ratio d" : "R6 ratio d"),
          32'(ratio_d), 32'(exp_d(mult, dv, md)));
      chk("R7 vco enable", 32'(vco_en), 32'(on | md));
      // STAT survives only if MULT/DIV/MODE unchanged and still in multiply mode
      lk = md && lk && (mult == pm) && (dv == pd) && (md == pmd);
      rd(4'd1, r); chk("R3 ctrl readback", 32'(r), 32'(ctrl_word(mult, dv, 8'd0, on, md, lk)));
      lk = md;
      chk("R9 lock state", 32'(lock), 32'(lk));
      pm = mult; pd = dv; pmd = md;
    end

    // R8 countdown timing
    wr(4'd1, ctrl_word(4'h0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0));
    chk("R9 mode0 no lock", 32'(lock), 0);
    wr(4'd1, ctrl_word(4'h3, 1'b0, 8'd3, 1'b0, 1'b1, 1'b0));
    edges_to_lock(cyc);
    chk("R8 lock edges N=3", 32'(cyc), 49);

    wr(4'd1, ctrl_word(4'h4, 1'b0, 8'd2, 1'b0, 1'b1, 1'b0));
    repeat (20) @(negedge clk);
    rd(4'd1, r); chk("R8 count midway", 32'(r), 32'(ctrl_word(4'h4, 1'b0, 8'd1, 1'b0, 1'b1, 1'b0)));
    edges_to_lock(cyc);
    chk("R8 lock edges remaining", 32'(cyc), 12);

    // R9: unchanged config write keeps lock
    wr(4'd1, ctrl_word(4'h4, 1'b0, 8'd9, 1'b1, 1'b1, 1'b0));
    chk("R9 lock kept", 32'(lock), 1);

    // R10 source switching
    wr(4'd0, 16'h0001);
    chk("R10 src not yet", 32'(src_sel), 0);
    @(negedge clk);
    chk("R10 src analog", 32'(src_sel), 1);
    rd(4'd0, r); chk("R10 sel status analog", 32'(r), 32'h0003);

    // R9 restart mid-count on config change
    wr(4'd1, ctrl_word(4'h5, 1'b0, 8'd5, 1'b0, 1'b1, 1'b0));
    chk("R9 lock cleared", 32'(lock), 0);
    @(negedge clk);
    chk("R10 src dropped", 32'(src_sel), 0);
    rd(4'd0, r); chk("R10 sel status digital", 32'(r), 32'h0005);
    repeat (27) @(negedge clk);
    wr(4'd1, ctrl_word(4'h6, 1'b0, 8'd1, 1'b0, 1'b1, 1'b0));
    edges_to_lock(cyc);
    chk("R9 restart from new count", 32'(cyc), 17);
    repeat (2) @(negedge clk);
    chk("R10 src analog again", 32'(src_sel), 1);
    wr(4'd0, 16'h0000);
    @(negedge clk);
    chk("R10 request off", 32'(src_sel), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule